// File: doc/BRIEF.md
# Trace Trigger Sequencer and Filter

This block decides, cycle by cycle, whether the instruction or data access currently presented to it belongs in the trace stream. It watches the executing instruction address, the data-access address and value, the running context ID and a few external event lines. From these it forms a bus of numbered events. Those events drive a start/stop latch, a three-state sequencer, reload counters and a one-shot trigger.

Address comparators are inclusive ranges. Each range can be used to include elements in the trace or to exclude them from it. Context-ID comparators each hold their own value and share one don't-care mask. All configuration arrives on static input ports. The block computes trace enable and trigger as registered outputs, one clock after the element they describe.

Top module: `trace_trigger_filter`

## Requirements
- R1: After synchronous reset the sequencer is in state 1 (`seq_state` = 1), `trace_en` and `trigger` are 0, the start/stop latch is clear and every counter holds its reload value.
- R2: Every selector field is 4 bits wide and picks one event by index: 0 never, 1 always, 2-3 range 0-1 hit, 4-5 context comparator 0-1 match, 6 data value match, 7-8 external input 0-1, 9-10 counter 0-1 zero event, 11-15 never.
- R3: Range i hits when its selected bus is valid and that bus's address lies between lo and hi, both ends included. `cfg_rng_on_data[i]`=0 selects the execute address, and 1 selects the data address.
- R4: Context comparator i matches when `ctx_id` equals its value in every bit where the shared mask is 0. The data value event needs `data_valid` and equality in every bit where its mask is 0.
- R5: `trace_en` in the cycle after an element is 1 only under all of these conditions: `exec_valid` or `data_valid` was high; no include bit is set, or an included range hit; no excluded range hit; and the start/stop condition holds.
- R6: With `cfg_ss_en`=1 the start event sets the latch and the stop event clears it, and start wins when both occur together. An element in the start cycle is traced, and an element in the stop cycle is not. With `cfg_ss_en`=0 the latch does not gate trace.
- R7: A counter decrements on its decrement event. A decrement from 1 reloads the counter and raises that counter's zero event for exactly the next cycle. The reload event reloads the counter and takes priority over a decrement in the same cycle.
- R8: The sequencer moves 1→2, 2→1, 2→3, 3→1 and 3→2 on the event picked by `cfg_seq_sel` slots 0 to 4 (4 bits each, in that order). When two moves are possible, the lower-numbered destination wins. The new state shows on `seq_state` after the clock edge.
- R9: When the sequencer is in `cfg_trig_state` and the `cfg_trig_sel` event occurs, `trigger` pulses high for one cycle on the next cycle. It stays low for all later events until `arm` has been high for a cycle, and no trigger arises from a cycle in which `arm` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | Execute-stage address valid |
| exec_addr | input | 32 | Execute-stage instruction address |
| data_valid | input | 1 | Data access valid |
| data_addr | input | 32 | Data access address |
| data_value | input | 32 | Data access value |
| ctx_id | input | 32 | Current context ID |
| ext_evt | input | 2 | External event inputs |
| cfg_rng_lo | input | 64 | Range lower bounds, 32 bits per range |
| cfg_rng_hi | input | 64 | Range upper bounds, 32 bits per range |
| cfg_rng_on_data | input | 2 | Per range: compare data address instead of execute address |
| cfg_rng_incl | input | 2 | Per range: include in trace |
| cfg_rng_excl | input | 2 | Per range: exclude from trace |
| cfg_cid_val | input | 64 | Context comparator values, 32 bits each |
| cfg_cid_mask | input | 32 | Shared context mask, 1 = ignore bit |
| cfg_dval_val | input | 32 | Data value to match |
| cfg_dval_mask | input | 32 | Data value mask, 1 = ignore bit |
| cfg_ss_en | input | 1 | Start/stop latch gates trace |
| cfg_start_sel | input | 4 | Start event selector |
| cfg_stop_sel | input | 4 | Stop event selector |
| cfg_cnt_reload | input | 32 | Counter reload values, 16 bits each |
| cfg_cnt_dec_sel | input | 8 | Counter decrement selectors |
| cfg_cnt_rld_sel | input | 8 | Counter reload selectors |
| cfg_seq_sel | input | 20 | Sequencer move selectors (1→2, 2→1, 2→3, 3→1, 3→2) |
| cfg_trig_state | input | 2 | Sequencer state in which trigger may fire |
| cfg_trig_sel | input | 4 | Trigger event selector |
| arm | input | 1 | Re-arm the one-shot trigger |
| trace_en | output | 1 | Registered trace enable for the previous element |
| trigger | output | 1 | Registered single-cycle trigger pulse |
| seq_state | output | 2 | Current sequencer state (1 to 3) |

## Verification
The filter is tested with execute addresses just inside, at and just outside each range bound, with nested include and exclude ranges, and with data-bus hits. These runs separate inclusive from exclusive comparison and bus selection from plain validity. Start/stop is tested with start alone, stop alone and both together, which shows the same-cycle visibility rules and start priority. Context IDs that differ only in masked bits and IDs that differ in unmasked bits distinguish the shared mask from exact equality. Counter and sequencer runs are arranged so that a wrong decrement, a lost reload priority or a wrong transition priority each leaves a different state on `seq_state`. A repeated trigger event before and after `arm` shows the one-shot behaviour.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    SEQ_S1 = 2'd1,
    SEQ_S2 = 2'd2,
    SEQ_S3 = 2'd3
  } seq_state_e;

  localparam int SEQ_MOVES = 5;  // 1->2, 2->1, 2->3, 3->1, 3->2
endpackage

// File: rtl/tt_range_cmp.sv
module tt_range_cmp #(
  parameter int AW = 32
) (
  input  logic          exec_valid,
  input  logic [AW-1:0] exec_addr,
  input  logic          data_valid,
  input  logic [AW-1:0] data_addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          on_data,
  output logic          hit
);
  logic [AW-1:0] addr;
  logic          vld;

  always_comb begin
    addr = on_data ? data_addr  : exec_addr;
    vld  = on_data ? data_valid : exec_valid;
    hit  = vld && (addr >= lo) && (addr <= hi);
  end
endmodule

// File: rtl/tt_mask_cmp.sv
module tt_mask_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] dont_care,
  output logic         match
);
  always_comb match = (((value ^ ref_val) & ~dont_care) == '0);
endmodule

// File: rtl/tt_event_counter.sv
module tt_event_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] reload_val,
  input  logic          dec,
  input  logic          rld,
  output logic          zero_ev
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= reload_val;
      zero_ev <= 1'b0;
    end else begin
      zero_ev <= 1'b0;
      if (rld) begin
        cnt <= reload_val;
      end else if (dec) begin
        if (cnt == CW'(1)) begin
          cnt     <= reload_val;
          zero_ev <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  // R7: a zero event only follows a decrement cycle
  a_r7_zero_after_dec: assert property (@(posedge clk) disable iff (rst)
    zero_ev |-> $past(dec) && !$past(rld));

  // R7: plain decrement steps by one
  a_r7_step_down: assert property (@(posedge clk) disable iff (rst)
    (dec && !rld && cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)) && !zero_ev);
endmodule

// File: rtl/tt_sequencer.sv
module tt_sequencer
  import tt_pkg::*;
#(
  parameter int EVW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [(1<<EVW)-1:0]        ev,
  input  logic [SEQ_MOVES*EVW-1:0]   move_sel,
  input  logic [1:0]                 trig_state,
  input  logic [EVW-1:0]             trig_sel,
  input  logic                       arm,
  output logic [1:0]                 state,
  output logic                       trigger
);
  seq_state_e st, st_nxt;
  logic [SEQ_MOVES-1:0] mv;
  logic fired, trig_cond;

  for (genvar k = 0; k < SEQ_MOVES; k++) begin : g_mv
    assign mv[k] = ev[move_sel[k*EVW +: EVW]];
  end

  always_comb begin
    st_nxt = st;
    case (st)
      SEQ_S1: if (mv[0]) st_nxt = SEQ_S2;
      SEQ_S2: if (mv[1]) st_nxt = SEQ_S1;
              else if (mv[2]) st_nxt = SEQ_S3;
      SEQ_S3: if (mv[3]) st_nxt = SEQ_S1;
              else if (mv[4]) st_nxt = SEQ_S2;
      default: st_nxt = SEQ_S1;
    endcase
  end

  assign trig_cond = !arm && !fired && (2'(st) == trig_state) && ev[trig_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_S1;
      fired   <= 1'b0;
      trigger <= 1'b0;
    end else begin
      st      <= st_nxt;
      trigger <= trig_cond;
      fired   <= arm ? 1'b0 : (fired | trig_cond);
    end
  end

  assign state = 2'(st);

  // R8: state never leaves the legal set
  a_r8_legal_state: assert property (@(posedge clk) disable iff (rst)
    state != 2'd0);

  // R8: state 1 cannot jump straight to 3
  a_r8_no_skip: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1) |=> (state != 2'd3));

  // R9: trigger is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trigger |=> !trigger);

  // R9: no trigger out of an arm cycle
  a_r9_arm_blocks: assert property (@(posedge clk) disable iff (rst)
    arm |=> !trigger);
endmodule

// File: rtl/trace_trigger_filter.sv
module trace_trigger_filter
  import tt_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int CIDW    = 32,
  parameter int N_RANGE = 2,
  parameter int N_CID   = 2,
  parameter int N_EXT   = 2,
  parameter int N_CNT   = 2,
  parameter int CNTW    = 16,
  parameter int EVW     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        exec_valid,
  input  logic [AW-1:0]               exec_addr,
  input  logic                        data_valid,
  input  logic [AW-1:0]               data_addr,
  input  logic [DW-1:0]               data_value,
  input  logic [CIDW-1:0]             ctx_id,
  input  logic [N_EXT-1:0]            ext_evt,
  input  logic [N_RANGE*AW-1:0]       cfg_rng_lo,
  input  logic [N_RANGE*AW-1:0]       cfg_rng_hi,
  input  logic [N_RANGE-1:0]          cfg_rng_on_data,
  input  logic [N_RANGE-1:0]          cfg_rng_incl,
  input  logic [N_RANGE-1:0]          cfg_rng_excl,
  input  logic [N_CID*CIDW-1:0]       cfg_cid_val,
  input  logic [CIDW-1:0]             cfg_cid_mask,
  input  logic [DW-1:0]               cfg_dval_val,
  input  logic [DW-1:0]               cfg_dval_mask,
  input  logic                        cfg_ss_en,
  input  logic [EVW-1:0]              cfg_start_sel,
  input  logic [EVW-1:0]              cfg_stop_sel,
  input  logic [N_CNT*CNTW-1:0]       cfg_cnt_reload,
  input  logic [N_CNT*EVW-1:0]        cfg_cnt_dec_sel,
  input  logic [N_CNT*EVW-1:0]        cfg_cnt_rld_sel,
  input  logic [SEQ_MOVES*EVW-1:0]    cfg_seq_sel,
  input  logic [1:0]                  cfg_trig_state,
  input  logic [EVW-1:0]              cfg_trig_sel,
  input  logic                        arm,
  output logic                        trace_en,
  output logic                        trigger,
  output logic [1:0]                  seq_state
);
  localparam int EV_RNG  = 2;
  localparam int EV_CID  = EV_RNG + N_RANGE;
  localparam int EV_DVAL = EV_CID + N_CID;
  localparam int EV_EXT  = EV_DVAL + 1;
  localparam int EV_CNT  = EV_EXT + N_EXT;
  localparam int NSLOT   = 1 << EVW;

  logic [N_RANGE-1:0] rng_hit;
  logic [N_CID-1:0]   cid_hit;
  logic               dval_eq, dval_hit;
  logic [N_CNT-1:0]   cnt_zero;
  logic [NSLOT-1:0]   ev;
  logic               ev_start, ev_stop;
  logic               latch, latch_nxt;
  logic               elem, incl_ok, excl_hit;

  for (genvar i = 0; i < N_RANGE; i++) begin : g_rng
    tt_range_cmp #(.AW(AW)) u_rng (
      .exec_valid (exec_valid),
      .exec_addr  (exec_addr),
      .data_valid (data_valid),
      .data_addr  (data_addr),
      .lo         (cfg_rng_lo[i*AW +: AW]),
      .hi         (cfg_rng_hi[i*AW +: AW]),
      .on_data    (cfg_rng_on_data[i]),
      .hit        (rng_hit[i])
    );
  end

  for (genvar i = 0; i < N_CID; i++) begin : g_cid
    tt_mask_cmp #(.W(CIDW)) u_cid (
      .value     (ctx_id),
      .ref_val   (cfg_cid_val[i*CIDW +: CIDW]),
      .dont_care (cfg_cid_mask),
      .match     (cid_hit[i])
    );
  end

  tt_mask_cmp #(.W(DW)) u_dval (
    .value     (data_value),
    .ref_val   (cfg_dval_val),
    .dont_care (cfg_dval_mask),
    .match     (dval_eq)
  );
  assign dval_hit = data_valid && dval_eq;

  always_comb begin
    ev = '0;
    ev[1] = 1'b1;
    for (int i = 0; i < N_RANGE; i++) ev[EV_RNG + i] = rng_hit[i];
    for (int i = 0; i < N_CID; i++)   ev[EV_CID + i] = cid_hit[i];
    ev[EV_DVAL] = dval_hit;
    for (int i = 0; i < N_EXT; i++)   ev[EV_EXT + i] = ext_evt[i];
    for (int i = 0; i < N_CNT; i++)   ev[EV_CNT + i] = cnt_zero[i];
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    tt_event_counter #(.CW(CNTW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .reload_val (cfg_cnt_reload[i*CNTW +: CNTW]),
      .dec        (ev[cfg_cnt_dec_sel[i*EVW +: EVW]]),
      .rld        (ev[cfg_cnt_rld_sel[i*EVW +: EVW]]),
      .zero_ev    (cnt_zero[i])
    );
  end

  tt_sequencer #(.EVW(EVW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .move_sel   (cfg_seq_sel),
    .trig_state (cfg_trig_state),
    .trig_sel   (cfg_trig_sel),
    .arm        (arm),
    .state      (seq_state),
    .trigger    (trigger)
  );

  // Filter: start/stop latch and include/exclude
  assign ev_start = ev[cfg_start_sel];
  assign ev_stop  = ev[cfg_stop_sel];

  always_comb begin
    if (ev_start)     latch_nxt = 1'b1;
    else if (ev_stop) latch_nxt = 1'b0;
    else              latch_nxt = latch;
    elem     = exec_valid || data_valid;
    incl_ok  = (cfg_rng_incl == '0) || |(cfg_rng_incl & rng_hit);
    excl_hit = |(cfg_rng_excl & rng_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch    <= 1'b0;
      trace_en <= 1'b0;
    end else begin
      latch    <= latch_nxt;
      trace_en <= elem && incl_ok && !excl_hit && (!cfg_ss_en || latch_nxt);
    end
  end

  // R5: nothing traced after a cycle with no element
  a_r5_idle_no_trace: assert property (@(posedge clk) disable iff (rst)
    (!exec_valid && !data_valid) |=> !trace_en);

  // R5: an excluded hit is never traced
  a_r5_excl_blocks: assert property (@(posedge clk) disable iff (rst)
    excl_hit |=> !trace_en);

  // R6: stop alone closes the gate in its own cycle
  a_r6_stop_closes: assert property (@(posedge clk) disable iff (rst)
    (cfg_ss_en && ev_stop && !ev_start) |=> !trace_en);
endmodule

// File: tb/trace_trigger_filter_test.sv
module trace_trigger_filter_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        exec_valid, data_valid;
  logic [31:0] exec_addr, data_addr, data_value, ctx_id;
  logic [1:0]  ext_evt;
  logic [63:0] cfg_rng_lo, cfg_rng_hi, cfg_cid_val;
  logic [1:0]  cfg_rng_on_data, cfg_rng_incl, cfg_rng_excl;
  logic [31:0] cfg_cid_mask, cfg_dval_val, cfg_dval_mask, cfg_cnt_reload;
  logic        cfg_ss_en;
  logic [3:0]  cfg_start_sel, cfg_stop_sel, cfg_trig_sel;
  logic [7:0]  cfg_cnt_dec_sel, cfg_cnt_rld_sel;
  logic [19:0] cfg_seq_sel;
  logic [1:0]  cfg_trig_state;
  logic        arm;
  logic        trace_en, trigger;
  logic [1:0]  seq_state;

  trace_trigger_filter uut (
    .clk(clk), .rst(rst),
    .exec_valid(exec_valid), .exec_addr(exec_addr),
    .data_valid(data_valid), .data_addr(data_addr), .data_value(data_value),
    .ctx_id(ctx_id), .ext_evt(ext_evt),
    .cfg_rng_lo(cfg_rng_lo), .cfg_rng_hi(cfg_rng_hi),
    .cfg_rng_on_data(cfg_rng_on_data), .cfg_rng_incl(cfg_rng_incl),
    .cfg_rng_excl(cfg_rng_excl), .cfg_cid_val(cfg_cid_val),
    .cfg_cid_mask(cfg_cid_mask), .cfg_dval_val(cfg_dval_val),
    .cfg_dval_mask(cfg_dval_mask), .cfg_ss_en(cfg_ss_en),
    .cfg_start_sel(cfg_start_sel), .cfg_stop_sel(cfg_stop_sel),
    .cfg_cnt_reload(cfg_cnt_reload), .cfg_cnt_dec_sel(cfg_cnt_dec_sel),
    .cfg_cnt_rld_sel(cfg_cnt_rld_sel), .cfg_seq_sel(cfg_seq_sel),
    .cfg_trig_state(cfg_trig_state), .cfg_trig_sel(cfg_trig_sel),
    .arm(arm), .trace_en(trace_en), .trigger(trigger), .seq_state(seq_state)
  );

  typedef struct {
    string      req;
    bit         chk_te;
    bit         te;
    bit         chk_tr;
    bit         tr;
    bit         chk_st;
    logic [1:0] st;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // Driver: inputs already set at the falling edge; push what the next edge must show
  task automatic tick(string req, bit ce, bit te, bit ct, bit tr, bit cs, logic [1:0] st);
    exp_t e;
    e.req = req; e.chk_te = ce; e.te = te; e.chk_tr = ct; e.tr = tr;
    e.chk_st = cs; e.st = st;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic te_step(string req, bit te);
    tick(req, 1'b1, te, 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic st_step(string req, logic [1:0] st);
    tick(req, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, st);
  endtask

  task automatic tr_step(string req, bit tr);
    tick(req, 1'b0, 1'b0, 1'b1, tr, 1'b0, 2'd0);
  endtask

  task automatic set_seq(logic [3:0] s12, logic [3:0] s21, logic [3:0] s23,
                         logic [3:0] s31, logic [3:0] s32);
    cfg_seq_sel = {s32, s31, s23, s21, s12};
  endtask

  // Monitor: compare one expected item per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk_te) begin
          checks++;
          if (trace_en !== e.te) begin
            errors++;
            $display("FAIL %s trace_en got %0b exp %0b", e.req, trace_en, e.te);
          end
        end
        if (e.chk_tr) begin
          checks++;
          if (trigger !== e.tr) begin
            errors++;
            $display("FAIL %s trigger got %0b exp %0b", e.req, trigger, e.tr);
          end
        end
        if (e.chk_st) begin
          checks++;
          if (seq_state !== e.st) begin
            errors++;
            $display("FAIL %s seq_state got %0d exp %0d", e.req, seq_state, e.st);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    exec_valid = 0; exec_addr = 0; data_valid = 0; data_addr = 0;
    data_value = 0; ctx_id = 0; ext_evt = 0; arm = 0;
    cfg_rng_lo  = {32'h180, 32'h100};
    cfg_rng_hi  = {32'h18F, 32'h1FF};
    cfg_rng_on_data = 0; cfg_rng_incl = 0; cfg_rng_excl = 0;
    cfg_cid_val = {32'hA0, 32'h55};
    cfg_cid_mask = 32'h0F;
    cfg_dval_val = 32'hDEAD; cfg_dval_mask = 0;
    cfg_ss_en = 0; cfg_start_sel = 0; cfg_stop_sel = 0;
    cfg_cnt_reload = {16'd2, 16'd3};
    cfg_cnt_dec_sel = 0; cfg_cnt_rld_sel = 0;
    set_seq(0, 0, 0, 0, 0);
    cfg_trig_state = 2'd1; cfg_trig_sel = 0;

    // R1 reset state
    tick("R1", 1, 0, 1, 0, 1, 2'd1);
    tick("R1", 1, 0, 1, 0, 1, 2'd1);
    rst = 1'b0;

    // R3 / R5 include and exclude, range 0 = 0x100..0x1FF, range 1 = 0x180..0x18F
    exec_valid = 1; cfg_rng_incl = 2'b01;
    exec_addr = 32'h150; te_step("R5 inside include", 1);
    exec_addr = 32'h200; te_step("R5 outside include", 0);
    exec_addr = 32'h100; te_step("R3 low bound inclusive", 1);
    exec_addr = 32'h1FF; te_step("R3 high bound inclusive", 1);
    exec_addr = 32'h0FF; te_step("R3 below low bound", 0);
    cfg_rng_excl = 2'b10;
    exec_addr = 32'h185; te_step("R5 excluded sub-range", 0);
    exec_addr = 32'h190; te_step("R5 past excluded", 1);
    exec_valid = 0; exec_addr = 32'h150; te_step("R5 no element", 0);
    cfg_rng_on_data = 2'b01; data_valid = 1; data_addr = 32'h120;
    te_step("R3 data bus range", 1);
    data_valid = 0; exec_valid = 1; exec_addr = 32'h150;
    te_step("R3 exec ignored when range on data", 0);
    cfg_rng_on_data = 0; cfg_rng_incl = 0; cfg_rng_excl = 0;
    exec_addr = 32'h999; te_step("R5 no include set", 1);

    // R6 start/stop with ext0 (event 7) start, ext1 (event 8) stop
    cfg_ss_en = 1; cfg_start_sel = 4'd7; cfg_stop_sel = 4'd8;
    ext_evt = 2'b00; te_step("R6 latch clear", 0);
    ext_evt = 2'b01; te_step("R6 start cycle traced R2", 1);
    ext_evt = 2'b00; te_step("R6 latch held", 1);
    ext_evt = 2'b10; te_step("R6 stop cycle not traced", 0);
    ext_evt = 2'b00; te_step("R6 latch stays clear", 0);
    ext_evt = 2'b11; te_step("R6 start wins", 1);
    ext_evt = 2'b00; te_step("R6 latch after tie", 1);
    ext_evt = 2'b10; te_step("R6 stop again", 0);
    ext_evt = 2'b00;

    // R4 context compare via start (event 4) and stop (event 5)
    cfg_start_sel = 4'd4; cfg_stop_sel = 4'd5;
    ctx_id = 32'h5A; te_step("R4 masked bits ignored", 1);
    ctx_id = 32'h65; te_step("R4 unmasked mismatch no stop", 1);
    ctx_id = 32'hA3; te_step("R4 comparator 1 match stops", 0);
    ctx_id = 32'h00; te_step("R4 no match stays stopped", 0);
    cfg_start_sel = 4'd6; cfg_stop_sel = 4'd0;
    data_valid = 1; data_addr = 32'h999; data_value = 32'hBEEF;
    te_step("R4 data value mismatch", 0);
    data_value = 32'hDEAD; te_step("R4 data value match", 1);
    data_valid = 0; te_step("R4 latch kept", 1);
    cfg_ss_en = 0; cfg_start_sel = 0; data_value = 0; exec_valid = 0;

    // R7 counter 0 reload 3, decremented by ext0, zero event moves 1->2
    set_seq(4'd9, 0, 0, 0, 0); cfg_cnt_dec_sel = {4'd0, 4'd7};
    ext_evt = 2'b01; st_step("R7 dec 3->2", 2'd1);
    st_step("R7 dec 2->1", 2'd1);
    st_step("R7 dec 1->zero", 2'd1);
    ext_evt = 2'b00; st_step("R7 zero event next cycle", 2'd2);

    // R7 / R8 counter 1 reload 2: dec ext1, reload ext0; 2->1 and 2->3 both on its zero
    set_seq(0, 4'd10, 4'd10, 0, 0);
    cfg_cnt_dec_sel = {4'd8, 4'd0}; cfg_cnt_rld_sel = {4'd7, 4'd0};
    ext_evt = 2'b10; st_step("R7 cnt1 2->1", 2'd2);
    ext_evt = 2'b11; st_step("R7 reload beats dec", 2'd2);
    ext_evt = 2'b00; st_step("R7 no zero after reload", 2'd2);
    ext_evt = 2'b10; st_step("R7 cnt1 2->1 again", 2'd2);
    ext_evt = 2'b10; st_step("R7 cnt1 reaches zero", 2'd2);
    ext_evt = 2'b00; st_step("R8 lower destination wins", 2'd1);
    cfg_cnt_dec_sel = 0; cfg_cnt_rld_sel = 0;

    // R8 transitions on ext inputs
    set_seq(4'd7, 4'd0, 4'd8, 4'd7, 4'd8);
    ext_evt = 2'b01; st_step("R8 1->2", 2'd2);
    ext_evt = 2'b10; st_step("R8 2->3", 2'd3);
    ext_evt = 2'b11; st_step("R8 3->1 beats 3->2", 2'd1);
    ext_evt = 2'b10; st_step("R8 state 1 ignores others", 2'd1);
    ext_evt = 2'b01; st_step("R8 1->2 again", 2'd2);
    ext_evt = 2'b10; st_step("R8 2->3 again", 2'd3);
    ext_evt = 2'b10; st_step("R8 3->2", 2'd2);
    ext_evt = 2'b00; set_seq(0, 0, 0, 0, 0);

    // R9 trigger in state 2 on ext0
    cfg_trig_state = 2'd2; cfg_trig_sel = 4'd7;
    ext_evt = 2'b01; tr_step("R9 first trigger", 1);
    ext_evt = 2'b01; tr_step("R9 one shot", 0);
    ext_evt = 2'b00; tr_step("R9 quiet", 0);
    arm = 1; ext_evt = 2'b01; tr_step("R9 no trigger in arm cycle", 0);
    arm = 0; tr_step("R9 re-armed fires", 1);
    ext_evt = 2'b00; tr_step("R9 pulse ends", 0);
    cfg_trig_state = 2'd3; arm = 1; tr_step("R9 arm", 0);
    arm = 0; ext_evt = 2'b01; tr_step("R9 wrong state", 0);
    ext_evt = 2'b00; st_step("R9 state held", 2'd2);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule